// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Unit

This unit holds the reservation state that lets a core build atomic read-modify-write sequences out of two ordinary memory operations. A load-locked request reserves the addressed granule of a small data cache. A later store-conditional request is allowed to write memory only if two things hold: a register condition that the unit evaluates itself, and a reservation that is still live for the addressed granule. The unit raises the memory write enable in the same cycle it decides. One cycle later it returns a full-width success word for the destination register.

A reservation granule is either a whole cache line or one 64-bit word inside a line, chosen by a parameter. Only one reservation is live at a time. Plain stores to the reserved granule and every store-conditional drop it. A context switch or interrupt entry, signalled on `clear_all`, wipes all reservations at once. This means a reservation cannot be silently lost and re-established between the load and the store.

Requests arrive as a single-cycle `req_valid` strobe with no ready. The unit accepts one request in every cycle and never applies back-pressure. The result strobe `sc_result_valid` is likewise one cycle wide with no ready, so the register write-back port must take it in the cycle it appears. Cache data, bypassing, decode and coherence snooping live outside the unit.

Top module: `llsc_resv_unit`

## Requirements
- R1: A request with `req_valid`=1 and `req_op`=2'b01 (load-locked) reserves the granule indexed by `req_addr[OFF_W +: IDX_W]`. With `WORD_GRAN`=1, OFF_W=3 and a granule is one 64-bit word. With `WORD_GRAN`=0, OFF_W=log2(`LINE_BYTES`) and a granule is one line. Addresses with equal index bits share the granule.
- R2: The condition of a store-conditional is chosen by `req_cond_sel`: 2'b00 means bit 0 of `req_cond_val` is set, 2'b01 means the top bit is set, 2'b10 means the value is zero, and 2'b11 means always true. `req_cond_inv`=1 inverts the selected condition.
- R3: A store-conditional (`req_op`=2'b10) drives `mem_we`=1 in its own request cycle exactly when its condition is true and its granule is reserved. `mem_we` is 0 in every other case.
- R4: A store-conditional drops the reservation of its granule, whether it succeeds or fails. A second store-conditional to the same granule then fails.
- R5: One cycle after a store-conditional, `sc_result_valid` is 1 for one cycle and `sc_result` is 1 on success or 0 on failure, zero-extended to `DATA_W`. No other operation produces `sc_result_valid`.
- R6: `clear_all`=1 drops every reservation. A load-locked in the same cycle does not reserve, and a store-conditional in the same cycle fails.
- R7: A plain store (`req_op`=2'b11) to the reserved granule drops that reservation. A store to a different granule, including another word of the same line when `WORD_GRAN`=1, leaves it in place.
- R8: A load-locked to a new granule replaces the previous reservation, so at most one reservation is live.
- R9: After reset no reservation is live, `mem_we` is 0 and `sc_result_valid` is 0.
- R10: A plain load (`req_op`=2'b00), or any request with `req_valid`=0, neither creates nor drops a reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_op | input | 2 | 00 load, 01 load-locked, 10 store-conditional, 11 store |
| req_addr | input | ADDR_W | Byte address of the access |
| req_cond_val | input | DATA_W | Register value tested by a store-conditional |
| req_cond_sel | input | 2 | Condition select, encoded as in R2 |
| req_cond_inv | input | 1 | Invert the selected condition |
| clear_all | input | 1 | Context switch or interrupt entry: wipe all reservations |
| mem_we | output | 1 | Memory write enable for a winning store-conditional |
| sc_result_valid | output | 1 | Success word is valid this cycle |
| sc_result | output | DATA_W | 1 on success, 0 on failure |

## Verification
The bench covers several corner cases, each tied to the fault it would expose:
- A store-conditional repeated right after a success. A unit that forgets to consume the reservation would write twice.
- Load-locked or store-conditional in the same cycle as `clear_all`. A unit with the wrong priority would let a stale reservation through.
- Stores to the neighbouring word of a reserved line, and to an aliasing address. These show whether word granularity and index matching are right.
- Inverted conditions against the all-ones and zero operands. A unit with a swapped select encoding or a missing invert would grant the wrong stores.

A long seeded random run over a small address pool covers the interleavings.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_LL    = 2'b01,
    OP_SC    = 2'b10,
    OP_STORE = 2'b11
  } llsc_op_e;

  typedef enum logic [1:0] {
    COND_LSB    = 2'b00,
    COND_MSB    = 2'b01,
    COND_ZERO   = 2'b10,
    COND_ALWAYS = 2'b11
  } llsc_cond_e;
endpackage

// File: rtl/llsc_index_map.sv
module llsc_index_map #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_GRAN  = 1,
  parameter int IDX_W      = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int WORD_OFF = 3;
  localparam int LINE_OFF = $clog2(LINE_BYTES);

  generate
    if (WORD_GRAN != 0) begin : g_word
      assign idx = addr[WORD_OFF +: IDX_W];
    end else begin : g_line
      assign idx = addr[LINE_OFF +: IDX_W];
    end
  endgenerate

  logic unused_addr_bits;
  assign unused_addr_bits = ^addr;
endmodule

// File: rtl/llsc_cond_eval.sv
module llsc_cond_eval
  import llsc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] val,
  input  logic [1:0]        sel,
  input  logic              inv,
  output logic              pass
);
  logic base;

  always_comb begin
    unique case (llsc_cond_e'(sel))
      COND_LSB:    base = val[0];
      COND_MSB:    base = val[DATA_W-1];
      COND_ZERO:   base = (val == '0);
      COND_ALWAYS: base = 1'b1;
      default:     base = 1'b0;
    endcase
    pass = base ^ inv;
  end
endmodule

// File: rtl/llsc_tag_array.sv
module llsc_tag_array #(
  parameter int NUM_TAGS = 32,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wipe,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                drop_en,
  input  logic [IDX_W-1:0]    drop_idx,
  input  logic [IDX_W-1:0]    look_idx,
  output logic                hit,
  output logic [NUM_TAGS-1:0] tags
);
  generate
    for (genvar i = 0; i < NUM_TAGS; i++) begin : g_tag
      logic nxt;
      always_comb begin
        if (wipe)
          nxt = 1'b0;
        else if (set_en)
          nxt = (set_idx == IDX_W'(i));
        else if (drop_en && (drop_idx == IDX_W'(i)))
          nxt = 1'b0;
        else
          nxt = tags[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tags[i] <= 1'b0;
        else        tags[i] <= nxt;
      end
    end
  endgenerate

  assign hit = tags[look_idx];
endmodule

// File: rtl/llsc_resv_unit.sv
module llsc_resv_unit
  import llsc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int NUM_LINES  = 8,
  parameter int LINE_BYTES = 32,
  parameter int WORD_GRAN  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_cond_val,
  input  logic [1:0]        req_cond_sel,
  input  logic              req_cond_inv,
  input  logic              clear_all,
  output logic              mem_we,
  output logic              sc_result_valid,
  output logic [DATA_W-1:0] sc_result
);
  localparam int WORDS_PER_LINE = LINE_BYTES / 8;
  localparam int NUM_TAGS = (WORD_GRAN != 0) ? NUM_LINES * WORDS_PER_LINE : NUM_LINES;
  localparam int IDX_W    = $clog2(NUM_TAGS);

  logic [IDX_W-1:0]    gran_idx;
  logic                cond_pass;
  logic                tag_hit;
  logic [NUM_TAGS-1:0] tag_q;
  logic                is_ll, is_sc, is_st;
  logic                sc_win;
  logic                res_valid_q, res_ok_q;

  assign is_ll = req_valid && (llsc_op_e'(req_op) == OP_LL);
  assign is_sc = req_valid && (llsc_op_e'(req_op) == OP_SC);
  assign is_st = req_valid && (llsc_op_e'(req_op) == OP_STORE);

  llsc_index_map #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WORD_GRAN(WORD_GRAN), .IDX_W(IDX_W)
  ) u_map (
    .addr(req_addr),
    .idx (gran_idx)
  );

  llsc_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .val (req_cond_val),
    .sel (req_cond_sel),
    .inv (req_cond_inv),
    .pass(cond_pass)
  );

  llsc_tag_array #(.NUM_TAGS(NUM_TAGS), .IDX_W(IDX_W)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wipe    (clear_all),
    .set_en  (is_ll),
    .set_idx (gran_idx),
    .drop_en (is_sc || is_st),
    .drop_idx(gran_idx),
    .look_idx(gran_idx),
    .hit     (tag_hit),
    .tags    (tag_q)
  );

  assign sc_win = is_sc && !clear_all && cond_pass && tag_hit;
  assign mem_we = sc_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_ok_q    <= 1'b0;
    end else begin
      res_valid_q <= is_sc;
      res_ok_q    <= sc_win;
    end
  end

  assign sc_result_valid = res_valid_q;
  assign sc_result       = {{(DATA_W-1){1'b0}}, res_ok_q};
endmodule

// File: rtl/llsc_resv_checker.sv
module llsc_resv_checker #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int NUM_TAGS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          req_op,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                clear_all,
  input logic                mem_we,
  input logic                sc_result_valid,
  input logic [DATA_W-1:0]   sc_result,
  input logic [NUM_TAGS-1:0] tags
);
  assert_we_only_sc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (req_valid && req_op == 2'b10));

  assert_clear_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |-> !mem_we);

  assert_after_clear_no_win_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_all) |-> !mem_we);

  assert_single_resv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tags));

  assert_result_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (sc_result_valid == $past(req_valid && req_op == 2'b10)));

  assert_result_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sc_result_valid |-> (sc_result[0] == $past(mem_we) && sc_result[DATA_W-1:1] == '0));

  assert_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_we) && req_valid && req_op == 2'b10 && req_addr == $past(req_addr)) |-> !mem_we);

  assert_reset_state_R9: assert property (@(posedge clk)
    !rst_n |=> (!sc_result_valid && tags == '0));
endmodule

bind llsc_resv_unit llsc_resv_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_TAGS(NUM_TAGS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_op         (req_op),
  .req_addr       (req_addr),
  .clear_all      (clear_all),
  .mem_we         (mem_we),
  .sc_result_valid(sc_result_valid),
  .sc_result      (sc_result),
  .tags           (tag_q)
);

// File: tb/tb_llsc_resv_unit.sv
`timescale 1ns/1ps
module tb_llsc_resv_unit;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam logic [1:0] LD = 2'b00, LL = 2'b01, SC = 2'b10, ST = 2'b11;
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [DATA_W-1:0] MSB1 = {1'b1, {(DATA_W-1){1'b0}}};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_op = 2'b00;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_cond_val = '0;
  logic [1:0]        req_cond_sel = 2'b00;
  logic              req_cond_inv = 1'b0;
  logic              clear_all = 1'b0;
  logic              mem_we;
  logic              sc_result_valid;
  logic [DATA_W-1:0] sc_result;

  int checks = 0;
  int failures = 0;

  bit       m_valid = 1'b0;
  bit [4:0] m_idx = '0;
  bit       exp_rv = 1'b0;
  bit       exp_rok = 1'b0;

  always #2.5 clk = ~clk;

  llsc_resv_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_cond_val(req_cond_val), .req_cond_sel(req_cond_sel),
    .req_cond_inv(req_cond_inv), .clear_all(clear_all), .mem_we(mem_we),
    .sc_result_valid(sc_result_valid), .sc_result(sc_result)
  );

  function automatic bit [4:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[7:3];
  endfunction

  function automatic bit cond_of(input logic [DATA_W-1:0] v, input logic [1:0] s, input logic i);
    bit b;
    case (s)
      2'b00: b = v[0];
      2'b01: b = v[DATA_W-1];
      2'b10: b = (v == '0);
      default: b = 1'b1;
    endcase
    return b ^ i;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] op, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] val, input logic [1:0] sel, input bit inv,
                      input bit clr, input string req);
    bit we_e;
    @(negedge clk);
    check(sc_result_valid == exp_rv, "R5", "result_valid", DATA_W'(sc_result_valid), DATA_W'(exp_rv));
    if (exp_rv)
      check(sc_result == DATA_W'(exp_rok), "R5", "result", sc_result, DATA_W'(exp_rok));
    req_valid = v; req_op = op; req_addr = a; req_cond_val = val;
    req_cond_sel = sel; req_cond_inv = inv; clear_all = clr;
    #1;
    we_e = v && op == SC && !clr && cond_of(val, sel, inv) && m_valid && m_idx == idx_of(a);
    check(mem_we == we_e, req, "mem_we", DATA_W'(mem_we), DATA_W'(we_e));
    exp_rv = v && op == SC;
    exp_rok = we_e;
    if (clr) m_valid = 1'b0;
    else if (v && op == LL) begin m_valid = 1'b1; m_idx = idx_of(a); end
    else if (v && (op == SC || op == ST) && idx_of(a) == m_idx) m_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_11c5));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sc_result_valid == 1'b0 && mem_we == 1'b0, "R9", "reset outputs",
          DATA_W'({sc_result_valid, mem_we}), '0);
    rst_n = 1'b1;
    // R9: no reservation after reset
    step(1, SC, 32'h100, '0, 2'b11, 0, 0, "R9");
    // R1/R2/R3: zero condition succeeds, then R4 second attempt fails
    step(1, LL, 32'h100, '0, 2'b00, 0, 0, "R1");
    step(1, SC, 32'h100, '0, 2'b10, 0, 0, "R3");
    step(1, SC, 32'h100, '0, 2'b10, 0, 0, "R4");
    // R4: failed condition still drops reservation
    step(1, LL, 32'h140, '0, 2'b00, 0, 0, "R1");
    step(1, SC, 32'h140, 64'h2, 2'b00, 0, 0, "R4");
    step(1, SC, 32'h140, 64'h1, 2'b00, 0, 0, "R4");
    // R2: MSB, invert, never
    step(1, LL, 32'h148, '0, 2'b00, 0, 0, "R1");
    step(1, SC, 32'h148, MSB1, 2'b01, 0, 0, "R2");
    step(1, LL, 32'h148, '0, 2'b00, 0, 0, "R1");
    step(1, SC, 32'h148, ONES, 2'b10, 1, 0, "R2");
    step(1, LL, 32'h148, '0, 2'b00, 0, 0, "R1");
    step(1, SC, 32'h148, ONES, 2'b11, 1, 0, "R2");
    // R6: clear same cycle as LL and as SC, and clear between
    step(1, LL, 32'h100, '0, 2'b00, 0, 1, "R6");
    step(1, SC, 32'h100, '0, 2'b11, 0, 0, "R6");
    step(1, LL, 32'h100, '0, 2'b00, 0, 0, "R1");
    step(1, SC, 32'h100, '0, 2'b11, 0, 1, "R6");
    step(1, LL, 32'h100, '0, 2'b00, 0, 0, "R1");
    step(0, LD, 32'h0, '0, 2'b00, 0, 1, "R6");
    step(1, SC, 32'h100, '0, 2'b11, 0, 0, "R6");
    // R7: neighbour word store keeps, same word store drops
    step(1, LL, 32'h100, '0, 2'b00, 0, 0, "R1");
    step(1, ST, 32'h108, '0, 2'b00, 0, 0, "R7");
    step(1, SC, 32'h100, '0, 2'b11, 0, 0, "R7");
    step(1, LL, 32'h100, '0, 2'b00, 0, 0, "R1");
    step(1, ST, 32'h104, '0, 2'b00, 0, 0, "R7");
    step(1, SC, 32'h100, '0, 2'b11, 0, 0, "R7");
    // R1: aliasing address shares the granule
    step(1, LL, 32'h100, '0, 2'b00, 0, 0, "R1");
    step(1, SC, 32'h200, '0, 2'b11, 0, 0, "R1");
    // R8: new LL replaces old
    step(1, LL, 32'h100, '0, 2'b00, 0, 0, "R8");
    step(1, LL, 32'h120, '0, 2'b00, 0, 0, "R8");
    step(1, SC, 32'h100, '0, 2'b11, 0, 0, "R8");
    step(1, SC, 32'h120, '0, 2'b11, 0, 0, "R8");
    // R10: loads and idle cycles keep the reservation
    step(1, LL, 32'h100, '0, 2'b00, 0, 0, "R1");
    step(1, LD, 32'h100, '0, 2'b00, 0, 0, "R10");
    step(0, ST, 32'h100, '0, 2'b00, 0, 0, "R10");
    step(0, SC, 32'h100, '0, 2'b11, 0, 0, "R10");
    step(1, SC, 32'h100, '0, 2'b11, 0, 0, "R10");
    // random mix over a small address pool
    for (int n = 0; n < 4000; n++) begin
      logic [ADDR_W-1:0] pool [4];
      logic [DATA_W-1:0] vals [4];
      pool[0] = 32'h100; pool[1] = 32'h108; pool[2] = 32'h120; pool[3] = 32'h200;
      vals[0] = '0; vals[1] = 64'h1; vals[2] = MSB1; vals[3] = {$urandom, $urandom};
      step($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)), pool[$urandom_range(0, 3)],
           vals[$urandom_range(0, 3)], 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           $urandom_range(0, 15) == 0, "R3");
    end
    step(0, LD, 32'h0, '0, 2'b00, 0, 0, "R5");
    step(0, LD, 32'h0, '0, 2'b00, 0, 0, "R5");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule